// File: doc/BRIEF.md
# Programmable Data-Enable Generator

This block rebuilds a video data-enable (DE) strobe on the pixel clock from the horizontal and vertical sync inputs. The timing comes from four programmable values: the number of lines skipped after the vertical sync leading edge, the number of pixels skipped after each horizontal sync leading edge, the active line width in pixels and the active screen height in lines. For interlaced input, the position of the vertical sync edge within its line tells the two fields apart. In the second field, an extra line offset is added to the vertical skip.

A force-generation input selects the source of the output. When it is set, the output carries the rebuilt DE. When it is clear, the incoming DE is copied to the output through the same register, so both paths have the same latency. Syncs are active high, and a leading edge is a low-to-high change between two samples. The configuration is captured only at a vertical sync leading edge, so a new setting always starts with a whole frame.

Internally, a horizontal state machine (H_IDLE, H_DELAY, H_ACTIVE, H_TAIL) marks the active pixels of each line, and a vertical state machine (V_IDLE, V_DELAY, V_ACTIVE, V_DONE) marks the active lines of each frame.

- Horizontal transitions:
  - Any horizontal leading edge moves the machine to H_DELAY, or straight to H_ACTIVE when the pixel skip is zero.
  - H_DELAY moves to H_ACTIVE when the pixel count reaches the skip.
  - H_ACTIVE moves to H_TAIL when the width is used up.
  - A zero width goes to H_TAIL in place of H_ACTIVE.
- Vertical transitions:
  - A vertical leading edge moves the machine from any state to V_DELAY with its line count cleared.
  - In V_DELAY, the horizontal leading edge that brings the count past the line skip moves it to V_ACTIVE.
  - V_ACTIVE moves to V_DONE once the height has been used up.
  - A zero height goes to V_DONE in place of V_ACTIVE.
  - V_IDLE holds from reset until the first vertical edge.

Top module: `de_regen`

## Requirements
- R1: While reset is asserted, and after it, both outputs are 0. With generation forced, DE stays 0 until the first vertical sync leading edge has been seen.
- R2: With force-generation clear, de_o equals de_i delayed by exactly one clock.
- R3: Pixel index 0 is the clock in which a horizontal leading edge is sampled. In an active line with generation forced, de_o is 1 exactly one clock after pixel indices H through H+W-1, where H is the pixel skip and W is the width. This includes H = 0.
- R4: Horizontal leading edges are numbered from 1 after a vertical leading edge. An edge in the same clock as the vertical edge counts as number 1. The lines started by edges V+1 through V+T are active, where V is the effective line skip and T is the height.
- R5: A horizontal leading edge that comes before the width is used up ends the active run. The new line restarts its pixel skip.
- R6: The line length is the distance in clocks between the last two horizontal leading edges. A vertical leading edge at a pixel index of at least half that length, not in the clock of a horizontal edge, marks field 1. Any other vertical leading edge marks field 0, and so does one seen before a line length has been measured. field_o takes the new value one clock after the vertical edge and holds it until the next one.
- R7: In field 1 the effective line skip is the programmed skip plus the 3-bit interlace offset. In field 0 it is the programmed skip alone.
- R8: Pixel skip, width, line skip, height and offset are captured at each vertical leading edge. Changes between two such edges do not affect the current frame.
- R9: A width of zero, or a height of zero, produces no DE in that frame.
- R10: A vertical leading edge in the middle of an active line drops de_o from that pixel on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Incoming data enable |
| force_gen_i | input | 1 | 1 selects the rebuilt DE, 0 passes de_i |
| vdelay_i | input | 6 | Lines skipped after the vertical edge (reset value 24) |
| hdelay_i | input | 10 | Pixels skipped after the horizontal edge (reset value 4) |
| width_i | input | 12 | Active pixels per line (reset value 1280) |
| height_i | input | 12 | Active lines per frame (reset value 720) |
| ilace_ofs_i | input | 3 | Extra line skip applied in field 1 |
| de_o | output | 1 | Registered data enable |
| field_o | output | 1 | Field flag, 1 for field 1 |

## Verification
The bound checker checks the following on every clock:
- the one-clock copy of de_i in pass-through mode;
- the absence of DE outside an active pixel or an active line;
- the DE gap that follows each horizontal and vertical edge;
- the stability of the field flag and the captured configuration between vertical edges.

The exact position and length of the active window, the extra lines of field 1, the choice of field by the position of the vertical edge, the delayed effect of a configuration change and the truncated short line can only be shown by the bench's frame scenarios. Those scenarios compare every output clock against a frame model and count the DE pulses in each frame.

// File: rtl/degen_pkg.sv
package degen_pkg;

    // Horizontal (per line) phases
    typedef enum logic [1:0] {
        H_IDLE   = 2'd0,
        H_DELAY  = 2'd1,
        H_ACTIVE = 2'd2,
        H_TAIL   = 2'd3
    } hstate_e;

    // Vertical (per frame) phases
    typedef enum logic [1:0] {
        V_IDLE   = 2'd0,
        V_DELAY  = 2'd1,
        V_ACTIVE = 2'd2,
        V_DONE   = 2'd3
    } vstate_e;

endpackage

// File: rtl/degen_line_timer.sv
// Sync edge detection, line length measurement and field decision input.
module degen_line_timer #(
    parameter int LEN_W = 13
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hsync_i,
    input  logic vsync_i,
    output logic hs_lead_o,
    output logic vs_lead_o,
    output logic late_half_o
);
    localparam logic [LEN_W-1:0] POS_MAX = {LEN_W{1'b1}};

    logic             hs_q;
    logic             vs_q;
    logic             seen_q;
    logic             len_ok_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] pos_d;
    logic [LEN_W-1:0] pos_inc;

    always_comb begin
        hs_lead_o = hsync_i & ~hs_q;
        vs_lead_o = vsync_i & ~vs_q;
        pos_inc   = (pos_q == POS_MAX) ? POS_MAX : pos_q + LEN_W'(1);
        pos_d     = hs_lead_o ? '0 : pos_inc;
        // Second half of a measured line, never at a line start
        late_half_o = !hs_lead_o && len_ok_q && (pos_d >= (len_q >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hs_q     <= 1'b0;
            vs_q     <= 1'b0;
            seen_q   <= 1'b0;
            len_ok_q <= 1'b0;
            pos_q    <= '0;
            len_q    <= '0;
        end else begin
            hs_q  <= hsync_i;
            vs_q  <= vsync_i;
            pos_q <= pos_d;
            if (hs_lead_o) begin
                seen_q <= 1'b1;
                if (seen_q) begin
                    len_q    <= pos_inc;
                    len_ok_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/degen_cfg_hold.sv
// Captures timing configuration and field flag at each vertical leading edge.
module degen_cfg_hold #(
    parameter int VD_W   = 6,
    parameter int HD_W   = 10,
    parameter int SZ_W   = 12,
    parameter int OFS_W  = 3,
    parameter int VDE_W  = 7,
    parameter int RST_VD = 24,
    parameter int RST_HD = 4,
    parameter int RST_WD = 1280,
    parameter int RST_HT = 720
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vs_lead_i,
    input  logic             late_half_i,
    input  logic [VD_W-1:0]  vdelay_i,
    input  logic [HD_W-1:0]  hdelay_i,
    input  logic [SZ_W-1:0]  width_i,
    input  logic [SZ_W-1:0]  height_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [VDE_W-1:0] vd_o,
    output logic [HD_W-1:0]  hd_o,
    output logic [SZ_W-1:0]  wd_o,
    output logic [SZ_W-1:0]  ht_o,
    output logic             field_o
);
    logic [VDE_W-1:0] vd_q;
    logic [HD_W-1:0]  hd_q;
    logic [SZ_W-1:0]  wd_q;
    logic [SZ_W-1:0]  ht_q;
    logic             field_q;
    logic [VDE_W-1:0] vd_new;

    always_comb begin
        vd_new = VDE_W'(vdelay_i) + (late_half_i ? VDE_W'(ofs_i) : '0);
        // New values apply from the very clock of the vertical edge
        vd_o   = vs_lead_i ? vd_new   : vd_q;
        hd_o   = vs_lead_i ? hdelay_i : hd_q;
        wd_o   = vs_lead_i ? width_i  : wd_q;
        ht_o   = vs_lead_i ? height_i : ht_q;
        field_o = field_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vd_q    <= VDE_W'(RST_VD);
            hd_q    <= HD_W'(RST_HD);
            wd_q    <= SZ_W'(RST_WD);
            ht_q    <= SZ_W'(RST_HT);
            field_q <= 1'b0;
        end else if (vs_lead_i) begin
            vd_q    <= vd_new;
            hd_q    <= hdelay_i;
            wd_q    <= width_i;
            ht_q    <= height_i;
            field_q <= late_half_i;
        end
    end

endmodule

// File: rtl/degen_hfsm.sv
// Per-line state machine: marks the active pixels of the current clock.
module degen_hfsm
    import degen_pkg::*;
#(
    parameter int HD_W = 10,
    parameter int SZ_W = 12
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hs_lead_i,
    input  logic [HD_W-1:0] hd_i,
    input  logic [SZ_W-1:0] wd_i,
    output logic            pix_act_o,
    output hstate_e         state_o
);
    localparam int CNT_W = (HD_W > SZ_W) ? HD_W : SZ_W;

    hstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
    hstate_e          first_run;

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        nxt       = cnt_q + CNT_W'(1);
        first_run = (wd_i == '0) ? H_TAIL : H_ACTIVE;
        if (hs_lead_i) begin
            cnt_d = '0;
            st_d  = (hd_i == '0) ? first_run : H_DELAY;
        end else begin
            unique case (st_q)
                H_IDLE: begin
                    st_d = H_IDLE;
                end
                H_DELAY: begin
                    if (nxt == CNT_W'(hd_i)) begin
                        cnt_d = '0;
                        st_d  = first_run;
                    end else begin
                        cnt_d = nxt;
                    end
                end
                H_ACTIVE: begin
                    if (nxt == CNT_W'(wd_i)) begin
                        st_d = H_TAIL;
                    end else begin
                        cnt_d = nxt;
                    end
                end
                H_TAIL: begin
                    st_d = H_TAIL;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= H_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        pix_act_o = (st_d == H_ACTIVE);
        state_o   = st_q;
    end

endmodule

// File: rtl/degen_vfsm.sv
// Per-frame state machine: marks whether the current line is active.
module degen_vfsm
    import degen_pkg::*;
#(
    parameter int SZ_W  = 12,
    parameter int VDE_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hs_lead_i,
    input  logic             vs_lead_i,
    input  logic [VDE_W-1:0] vd_i,
    input  logic [SZ_W-1:0]  ht_i,
    output logic             line_act_o,
    output vstate_e          state_o
);
    localparam int CNT_W = ((SZ_W > VDE_W) ? SZ_W : VDE_W) + 1;

    vstate_e          st_q, st_b, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_b, cnt_d, nxt;

    always_comb begin
        // A vertical edge restarts the frame, even with a line edge alongside
        st_b  = vs_lead_i ? V_DELAY : st_q;
        cnt_b = vs_lead_i ? '0 : cnt_q;
        st_d  = st_b;
        cnt_d = cnt_b;
        nxt   = cnt_b + CNT_W'(1);
        if (hs_lead_i) begin
            unique case (st_b)
                V_IDLE: begin
                    st_d = V_IDLE;
                end
                V_DELAY: begin
                    if (nxt > CNT_W'(vd_i)) begin
                        cnt_d = CNT_W'(1);
                        st_d  = (ht_i == '0) ? V_DONE : V_ACTIVE;
                    end else begin
                        cnt_d = nxt;
                    end
                end
                V_ACTIVE: begin
                    if (cnt_b == CNT_W'(ht_i)) begin
                        st_d = V_DONE;
                    end else begin
                        cnt_d = nxt;
                    end
                end
                V_DONE: begin
                    st_d = V_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= V_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        line_act_o = (st_d == V_ACTIVE);
        state_o    = st_q;
    end

endmodule

// File: rtl/de_regen.sv
module de_regen
    import degen_pkg::*;
#(
    parameter int VD_W   = 6,
    parameter int HD_W   = 10,
    parameter int SZ_W   = 12,
    parameter int OFS_W  = 3,
    parameter int RST_VD = 24,
    parameter int RST_HD = 4,
    parameter int RST_WD = 1280,
    parameter int RST_HT = 720
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             de_i,
    input  logic             force_gen_i,
    input  logic [VD_W-1:0]  vdelay_i,
    input  logic [HD_W-1:0]  hdelay_i,
    input  logic [SZ_W-1:0]  width_i,
    input  logic [SZ_W-1:0]  height_i,
    input  logic [OFS_W-1:0] ilace_ofs_i,
    output logic             de_o,
    output logic             field_o
);
    localparam int VDE_W = ((VD_W > OFS_W) ? VD_W : OFS_W) + 1;
    localparam int LEN_W = SZ_W + 1;

    logic             hs_lead;
    logic             vs_lead;
    logic             late_half;
    logic [VDE_W-1:0] vd_eff;
    logic [HD_W-1:0]  hd_eff;
    logic [SZ_W-1:0]  wd_eff;
    logic [SZ_W-1:0]  ht_eff;
    logic             pix_act;
    logic             line_act;
    hstate_e          h_state;
    vstate_e          v_state;
    logic             de_gen;
    logic             de_q;

    degen_line_timer #(.LEN_W(LEN_W)) timer_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hsync_i     (hsync_i),
        .vsync_i     (vsync_i),
        .hs_lead_o   (hs_lead),
        .vs_lead_o   (vs_lead),
        .late_half_o (late_half)
    );

    degen_cfg_hold #(
        .VD_W   (VD_W),
        .HD_W   (HD_W),
        .SZ_W   (SZ_W),
        .OFS_W  (OFS_W),
        .VDE_W  (VDE_W),
        .RST_VD (RST_VD),
        .RST_HD (RST_HD),
        .RST_WD (RST_WD),
        .RST_HT (RST_HT)
    ) cfg_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .vs_lead_i   (vs_lead),
        .late_half_i (late_half),
        .vdelay_i    (vdelay_i),
        .hdelay_i    (hdelay_i),
        .width_i     (width_i),
        .height_i    (height_i),
        .ofs_i       (ilace_ofs_i),
        .vd_o        (vd_eff),
        .hd_o        (hd_eff),
        .wd_o        (wd_eff),
        .ht_o        (ht_eff),
        .field_o     (field_o)
    );

    degen_hfsm #(.HD_W(HD_W), .SZ_W(SZ_W)) hfsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hs_lead_i (hs_lead),
        .hd_i      (hd_eff),
        .wd_i      (wd_eff),
        .pix_act_o (pix_act),
        .state_o   (h_state)
    );

    degen_vfsm #(.SZ_W(SZ_W), .VDE_W(VDE_W)) vfsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hs_lead_i  (hs_lead),
        .vs_lead_i  (vs_lead),
        .vd_i       (vd_eff),
        .ht_i       (ht_eff),
        .line_act_o (line_act),
        .state_o    (v_state)
    );

    always_comb de_gen = pix_act & line_act;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            de_q <= 1'b0;
        end else begin
            de_q <= force_gen_i ? de_gen : de_i;
        end
    end

    always_comb de_o = de_q;

endmodule

// File: rtl/degen_chk.sv
module degen_chk
    import degen_pkg::*;
#(
    parameter int HD_W  = 10,
    parameter int SZ_W  = 12,
    parameter int VDE_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             force_i,
    input logic             de_in_i,
    input logic             de_o,
    input logic             field_o,
    input logic             hs_lead,
    input logic             vs_lead,
    input logic             pix_act,
    input logic             line_act,
    input logic [VDE_W-1:0] vd_eff,
    input logic [HD_W-1:0]  hd_eff,
    input logic [SZ_W-1:0]  wd_eff,
    input logic [SZ_W-1:0]  ht_eff
);
    logic pv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pv_q <= 1'b0;
        else         pv_q <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (!de_o && !field_o));

    assert_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        !force_i |=> (de_o == $past(de_in_i)));

    assert_de_needs_pixel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        (force_i && !pix_act) |=> !de_o);

    assert_de_needs_line_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        (force_i && !line_act) |=> !de_o);

    assert_hs_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        (force_i && hs_lead && (hd_eff != '0)) |=> !de_o);

    assert_field_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        !vs_lead |=> $stable(field_o));

    assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        !vs_lead |=> (vs_lead || ($stable(vd_eff) && $stable(hd_eff)
                                  && $stable(wd_eff) && $stable(ht_eff))));

    assert_vs_cut_R10: assert property (@(posedge clk_i) disable iff (!rst_ni || !pv_q)
        (force_i && vs_lead && !hs_lead) |=> !de_o);

endmodule

bind de_regen degen_chk #(
    .HD_W  (HD_W),
    .SZ_W  (SZ_W),
    .VDE_W (VDE_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .force_i  (force_gen_i),
    .de_in_i  (de_i),
    .de_o     (de_o),
    .field_o  (field_o),
    .hs_lead  (hs_lead),
    .vs_lead  (vs_lead),
    .pix_act  (pix_act),
    .line_act (line_act),
    .vd_eff   (vd_eff),
    .hd_eff   (hd_eff),
    .wd_eff   (wd_eff),
    .ht_eff   (ht_eff)
);

// File: tb/de_regen_tb_top.sv
module de_regen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs = 1'b0;
    logic        vs = 1'b0;
    logic        din = 1'b0;
    logic        frc = 1'b0;
    logic [5:0]  cfg_vd = 6'd2;
    logic [9:0]  cfg_hd = 10'd3;
    logic [11:0] cfg_wd = 12'd5;
    logic [11:0] cfg_ht = 12'd3;
    logic [2:0]  cfg_ofs = 3'd0;
    logic        de_o;
    logic        field_o;

    int n_chk = 0;
    int n_err = 0;

    // frame model state
    bit m_prev_hs, m_prev_vs, m_seen, m_vstart, m_lact, m_field;
    int m_pos, m_len, m_line;
    int c_hd, c_wd, c_vd, c_ht;
    bit exp_de, exp_field;

    // per-frame observations
    int de_seen, din_cnt, first_line, cur_line;
    // alternate configuration for mid-frame change
    int alt_hd, alt_wd, alt_vd, alt_ht;

    always #5 clk = ~clk;

    de_regen dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .hsync_i     (hs),
        .vsync_i     (vs),
        .de_i        (din),
        .force_gen_i (frc),
        .vdelay_i    (cfg_vd),
        .hdelay_i    (cfg_hd),
        .width_i     (cfg_wd),
        .height_i    (cfg_ht),
        .ilace_ofs_i (cfg_ofs),
        .de_o        (de_o),
        .field_o     (field_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model(input bit h, input bit v, input bit d);
        bit hl, vl, f1, gen;
        int pos;
        hl  = h && !m_prev_hs;
        vl  = v && !m_prev_vs;
        pos = hl ? 0 : m_pos + 1;
        f1  = !hl && (m_len != 0) && (pos >= m_len / 2);
        if (hl) begin
            if (m_seen) m_len = m_pos + 1;
            m_seen = 1'b1;
        end
        m_pos = pos;
        if (vl) begin
            m_field  = f1;
            c_hd     = int'(cfg_hd);
            c_wd     = int'(cfg_wd);
            c_ht     = int'(cfg_ht);
            c_vd     = int'(cfg_vd) + (f1 ? int'(cfg_ofs) : 0);
            m_vstart = 1'b1;
            m_line   = 0;
            m_lact   = 1'b0;
        end
        if (hl && m_vstart) begin
            m_line++;
            m_lact = (m_line > c_vd) && (m_line <= c_vd + c_ht);
        end
        gen       = m_lact && (pos >= c_hd) && (pos < c_hd + c_wd);
        exp_de    = frc ? gen : d;
        exp_field = m_field;
        m_prev_hs = h;
        m_prev_vs = v;
    endtask

    task automatic step(input bit h, input bit v, input bit d, input string tag);
        hs  = h;
        vs  = v;
        din = d;
        model(h, v, d);
        @(posedge clk);
        @(negedge clk);
        check(de_o === exp_de, tag, "de_o", int'(de_o), int'(exp_de));
        check(field_o === exp_field, tag, "field_o", int'(field_o), int'(exp_field));
        if (de_o === 1'b1) begin
            de_seen++;
            if (first_line < 0) first_line = cur_line;
        end
    endtask

    // One frame: hsync two clocks wide, vsync one line long starting at (vl, vp)
    task automatic gen_frame(input int nlines, input int llen, input int vl, input int vp,
                             input int chg_line, input string tag);
        de_seen    = 0;
        din_cnt    = 0;
        first_line = -1;
        for (int l = 0; l < nlines; l++) begin
            cur_line = l;
            if (l == chg_line) begin
                cfg_hd = 10'(alt_hd);
                cfg_wd = 12'(alt_wd);
                cfg_vd = 6'(alt_vd);
                cfg_ht = 12'(alt_ht);
            end
            for (int p = 0; p < llen; p++) begin
                bit h, v, d;
                h = (p < 2);
                v = ((l == vl) && (p >= vp)) || ((l == vl + 1) && (p < vp));
                d = ((p % 3) == 1);
                if (d) din_cnt++;
                step(h, v, d, tag);
            end
        end
    endtask

    task automatic set_cfg(input int hd, input int wd, input int vd, input int ht, input int ofs);
        cfg_hd  = 10'(hd);
        cfg_wd  = 12'(wd);
        cfg_vd  = 6'(vd);
        cfg_ht  = 12'(ht);
        cfg_ofs = 3'(ofs);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        frc   = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(de_o === 1'b0, "R1", "de_o in reset", int'(de_o), 0);
            check(field_o === 1'b0, "R1", "field_o in reset", int'(field_o), 0);
        end
        rst_n = 1'b1;
        // no vertical edge yet: generation must stay silent
        gen_frame(4, 16, -5, 0, -1, "R1");
        check(de_seen == 0, "R1", "DE before first vsync", de_seen, 0);
    endtask

    task automatic t_passthru;
        frc = 1'b0;
        gen_frame(6, 16, 0, 0, -1, "R2");
        check(de_seen == din_cnt, "R2", "copied DE count", de_seen, din_cnt);
    endtask

    task automatic t_progressive;
        frc = 1'b1;
        set_cfg(3, 5, 2, 3, 0);
        for (int f = 0; f < 2; f++) begin
            gen_frame(8, 16, 0, 0, -1, "R3 R4");
            check(de_seen == 15, "R3", "DE pixels per frame", de_seen, 15);
            check(first_line == 2, "R4", "first active line", first_line, 2);
        end
        set_cfg(0, 5, 0, 2, 0);
        gen_frame(8, 16, 0, 0, -1, "R3 zero skip");
        check(de_seen == 10, "R3", "DE pixels with zero skip", de_seen, 10);
        check(first_line == 0, "R4", "first line with zero skip", first_line, 0);
    endtask

    task automatic t_short_line;
        set_cfg(3, 5, 2, 3, 0);
        gen_frame(8, 6, 0, 0, -1, "R5");
        check(de_seen == 9, "R5", "DE pixels on short lines", de_seen, 9);
        gen_frame(8, 16, 0, 0, -1, "R5 restore");
        check(de_seen == 15, "R5", "DE pixels after restore", de_seen, 15);
    endtask

    task automatic t_interlace;
        set_cfg(3, 5, 2, 3, 1);
        gen_frame(8, 16, 0, 10, -1, "R6 R7");
        check(field_o === 1'b1, "R6", "field after late vsync", int'(field_o), 1);
        check(first_line == 4, "R7", "field 1 first line", first_line, 4);
        check(de_seen == 15, "R7", "field 1 DE pixels", de_seen, 15);
        gen_frame(8, 16, 0, 0, -1, "R6 R7");
        check(field_o === 1'b0, "R6", "field after early vsync", int'(field_o), 0);
        check(first_line == 2, "R7", "field 0 first line", first_line, 2);
        set_cfg(3, 5, 2, 3, 0);
        gen_frame(8, 16, 0, 10, -1, "R7 zero offset");
        check(first_line == 3, "R7", "field 1 without offset", first_line, 3);
    endtask

    task automatic t_cfg_change;
        set_cfg(3, 5, 2, 3, 0);
        alt_hd = 1;
        alt_wd = 7;
        alt_vd = 1;
        alt_ht = 2;
        gen_frame(8, 16, 0, 0, 3, "R8");
        check(de_seen == 15, "R8", "frame keeps captured config", de_seen, 15);
        gen_frame(8, 16, 0, 0, -1, "R8");
        check(de_seen == 14, "R8", "next frame uses new config", de_seen, 14);
        check(first_line == 1, "R8", "new line skip", first_line, 1);
    endtask

    task automatic t_zero;
        set_cfg(3, 0, 2, 3, 0);
        gen_frame(8, 16, 0, 0, -1, "R9");
        check(de_seen == 0, "R9", "zero width", de_seen, 0);
        set_cfg(3, 5, 2, 0, 0);
        gen_frame(8, 16, 0, 0, -1, "R9");
        check(de_seen == 0, "R9", "zero height", de_seen, 0);
    endtask

    task automatic t_vcut;
        set_cfg(3, 5, 2, 3, 0);
        gen_frame(3, 16, 0, 0, -1, "R10 lead");
        check(de_seen == 5, "R10", "lead-in DE pixels", de_seen, 5);
        gen_frame(8, 16, 0, 5, -1, "R10");
        check(de_seen == 17, "R10", "DE pixels with cut line", de_seen, 17);
        check(field_o === 1'b0, "R10", "early vsync field", int'(field_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_passthru();
        t_progressive();
        t_short_line();
        t_interlace();
        t_cfg_change();
        t_zero();
        t_vcut();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule